// File: doc/BRIEF.md
# Tone Presence Detector

This block watches a squared tone signal, the output of an analog comparator that follows a coupling network, and tells the rest of the receiver whether a tone burst near 22 kHz is on the line. It runs on a fast system clock. It times the gap between successive rising edges of the squared input in clock cycles and checks each gap against a capture band that spans 17.6 kHz to 26.4 kHz. Its output goes low while a tone is present and goes high when there is none.

A single in-band period is enough to declare presence. Presence ends when a period falls outside the band, or when no rising edge arrives within the longest allowed period. Both decisions therefore land within about one tone cycle of the true burst edges, so a downstream decoder can recover burst lengths to a precision of one cycle. The input is asynchronous to the system clock and passes through a synchronizer before any edge is taken from it.

Top module: `tone_presence_det`

## Requirements
- R1: Reset is synchronous and active low. After any clock edge that samples `rst_n` low, `tone_det_n` is high. All edge history is cleared, so the first rising input edge after reset never asserts presence.
- R2: `tone_sq` passes through a two-flop synchronizer. A presence decision that is caused by a rising input edge appears on `tone_det_n` after the third rising clock edge, counting from the edge that first samples `tone_sq` high.
- R3: A period is the number of clock cycles between two consecutive rising input edges. LO_CNT = floor(CLK_HZ/HI_HZ) and HI_CNT = floor(CLK_HZ/LO_HZ), which gives 151 and 227 with the defaults (4 MHz, 26.4 kHz, 17.6 kHz). A rising edge that closes a period in [LO_CNT, HI_CNT] drives `tone_det_n` low, where low means a tone is present.
- R4: A rising edge that closes a period shorter than LO_CNT drives `tone_det_n` high. This covers an extra glitch edge inside a tone cycle.
- R5: If HI_CNT cycles pass after the last detected rising edge with no new one, `tone_det_n` goes high on that edge. With the defaults, the output is high at the 230th falling clock edge after the input was raised for the last time.
- R6: Periods of exactly LO_CNT and exactly HI_CNT are accepted. Periods of LO_CNT-1 and HI_CNT+1 are rejected.
- R7: Only rising input edges matter. A duty cycle anywhere from 10% to 90% at a valid period keeps the tone present.
- R8: The period counter saturates at HI_CNT+1 and does not wrap. After any silence, however long, the first rising edge does not assert presence, and the next edge in band does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tone_sq | input | 1 | Squared tone from the comparator, asynchronous |
| tone_det_n | output | 1 | Low while a tone is present |

## Verification
The bench checks periods at each edge of the capture band: exactly the shortest and longest accepted counts, and one cycle beyond each. A design with an off-by-one in its counter start or its comparison would flip the output for one of these four periods. It measures the exact cycle at which presence ends after a burst stops. A timeout that waits for an overflowed count, or that fires a cycle early, shows up as a one-cycle shift that the cycle-by-cycle model catches. It also injects a glitch edge mid-cycle, drives extreme duty cycles, holds the line silent for far longer than the counter range, and applies reset in the middle of a burst. A counter that wraps, or a detector that uses falling edges, would declare a tone falsely or drop it under these patterns.

// File: rtl/tone_det_pkg.sv
// Package: shared types and helpers for the tone presence detector.
// Assumes integer clock and tone frequencies in Hz.
package tone_det_pkg;

    // Classification of one clock cycle as seen by the period timer.
    typedef enum logic [1:0] {
        PER_IDLE   = 2'd0,  // no rising edge in this cycle
        PER_SHORT  = 2'd1,  // edge closed a period below the band
        PER_INBAND = 2'd2,  // edge closed a period inside the band
        PER_LONG   = 2'd3   // edge closed a period above the band
    } period_cls_e;

    // Number of whole clock cycles in one period of the given tone.
    function automatic int cycles_per_period(input int clk_hz, input int tone_hz);
        return clk_hz / tone_hz;
    endfunction

endpackage

// File: rtl/tone_det_sync.sv
// Module: multi-stage synchronizer for the asynchronous squared tone.
// Assumes STAGES >= 2. Reset clears every stage to zero synchronously.
module tone_det_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain, stage 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/tone_det_edge.sv
// Module: rising-edge detector on the synchronized tone level.
// Assumes the input is already synchronous to clk. Reset clears the history,
// so a level that is high right after reset does count as a rising edge.
module tone_det_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    // Hold the previous cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/tone_det_period.sv
// Module: saturating period timer and band classifier.
// The count equals the cycles elapsed since the last rising edge, so at the
// next edge it equals the period. The count saturates at HI_CNT+1, which also
// marks "no previous edge" after reset.
module tone_det_period
    import tone_det_pkg::*;
#(
    parameter int LO_CNT = 151,
    parameter int HI_CNT = 227,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt,
    output period_cls_e      cls,
    output logic             expiring
);

    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(LO_CNT);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_CNT);
    localparam logic [CNT_W-1:0] SAT    = CNT_W'(HI_CNT + 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    // Restart at one on an edge, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= SAT;
        end else if (rise) begin
            cnt <= ONE;
        end else if (cnt != SAT) begin
            cnt <= cnt + ONE;
        end
    end

    // Classify the period closed by the current edge.
    always_comb begin
        if (!rise) begin
            cls = PER_IDLE;
        end else if (cnt < LO_LIM) begin
            cls = PER_SHORT;
        end else if (cnt > HI_LIM) begin
            cls = PER_LONG;
        end else begin
            cls = PER_INBAND;
        end
    end

    // The longest period has run out and no edge came to close it.
    assign expiring = !rise && (cnt == HI_LIM);

endmodule

// File: rtl/tone_det_presence.sv
// Module: presence flag driven by period classification.
// Sets on an in-band period and clears on an out-of-band period or on timeout.
module tone_det_presence
    import tone_det_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  period_cls_e cls,
    input  logic        expiring,
    output logic        present
);

    // Update presence on each edge decision or on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present <= 1'b0;
        end else if (cls != PER_IDLE) begin
            present <= (cls == PER_INBAND);
        end else if (expiring) begin
            present <= 1'b0;
        end
    end

endmodule

// File: rtl/tone_presence_det.sv
// Top: tone presence detector. Measures rising-to-rising periods of the
// squared tone in system clock cycles and drives an active-low presence
// output. Assumes CLK_HZ is far above HI_HZ, so that a period spans many
// cycles, and that tone_sq is asynchronous to clk.
module tone_presence_det
    import tone_det_pkg::*;
#(
    parameter int CLK_HZ      = 4_000_000,
    parameter int LO_HZ       = 17_600,
    parameter int HI_HZ       = 26_400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_sq,
    output logic tone_det_n
);

    localparam int LO_CNT = cycles_per_period(CLK_HZ, HI_HZ);
    localparam int HI_CNT = cycles_per_period(CLK_HZ, LO_HZ);
    localparam int CNT_W  = $clog2(HI_CNT + 2);

    logic             tone_sync;
    logic             rise_pulse;
    logic [CNT_W-1:0] period_cnt;
    period_cls_e      period_cls;
    logic             period_expiring;
    logic             tone_present;

    tone_det_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tone_sq),
        .sync_out (tone_sync)
    );

    tone_det_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (tone_sync),
        .rise  (rise_pulse)
    );

    tone_det_period #(
        .LO_CNT (LO_CNT),
        .HI_CNT (HI_CNT),
        .CNT_W  (CNT_W)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_pulse),
        .cnt      (period_cnt),
        .cls      (period_cls),
        .expiring (period_expiring)
    );

    tone_det_presence u_presence (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (period_cls),
        .expiring (period_expiring),
        .present  (tone_present)
    );

    assign tone_det_n = ~tone_present;

endmodule

// File: rtl/tone_presence_det_chk.sv
// Checker: temporal properties of the tone presence detector, bound to the top.
module tone_presence_det_chk #(
    parameter int LO_CNT = 151,
    parameter int HI_CNT = 227,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic [CNT_W-1:0] cnt,
    input logic             tone_det_n
);

    // R1: a reset edge leaves the output released.
    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> tone_det_n);

    // R3: presence begins only on an edge that closes an in-band period.
    a_r3_assert_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(tone_det_n)) |->
            ($past(rise) && $past(cnt) >= CNT_W'(LO_CNT) && $past(cnt) <= CNT_W'(HI_CNT)));

    // R4, R6: an out-of-band period leaves the output released.
    a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (cnt < CNT_W'(LO_CNT) || cnt > CNT_W'(HI_CNT))) |=> tone_det_n);

    // R5: timeout releases the output.
    a_r5_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && cnt == CNT_W'(HI_CNT)) |=> tone_det_n);

    // R5: release only follows an edge decision or a timeout.
    a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(tone_det_n)) |->
            ($past(rise) || $past(cnt) == CNT_W'(HI_CNT)));

    // R8: the period count never passes its saturation value.
    a_r8_cnt_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HI_CNT + 1));

    // R8: each edge restarts the period count.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt == CNT_W'(1)));

endmodule

bind tone_presence_det tone_presence_det_chk #(
    .LO_CNT (LO_CNT),
    .HI_CNT (HI_CNT),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise_pulse),
    .cnt        (period_cnt),
    .tone_det_n (tone_det_n)
);

// File: tb/tone_presence_det_test.sv
// Bench: behavioural reference model compared with the output on every clock,
// plus point checks at the corner cases of each requirement.
module tone_presence_det_test;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int LO_HZ      = 17_600;
    localparam int HI_HZ      = 26_400;
    localparam int SHORTEST   = CLK_HZ / HI_HZ;   // 151
    localparam int LONGEST    = CLK_HZ / LO_HZ;   // 227
    localparam int NOM        = CLK_HZ / 22_000;  // 181

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_sq = 1'b0;
    logic tone_det_n;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    tone_presence_det #(
        .CLK_HZ      (CLK_HZ),
        .LO_HZ       (LO_HZ),
        .HI_HZ       (HI_HZ),
        .SYNC_STAGES (2)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_sq    (tone_sq),
        .tone_det_n (tone_det_n)
    );

    // Reference model: sample history queue, elapsed-cycle integer, presence bit.
    bit hist[$];
    int elapsed = 0;
    bit m_present = 1'b0;
    bit model_ready = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0, 0};
            elapsed = LONGEST + 1;
            m_present = 1'b0;
        end else begin
            hist.push_front(tone_sq);
            void'(hist.pop_back());
            if (hist[2] && !hist[3]) begin
                m_present = (elapsed >= SHORTEST) && (elapsed <= LONGEST);
                elapsed = 1;
            end else begin
                if (elapsed == LONGEST) m_present = 1'b0;
                if (elapsed <= LONGEST) elapsed++;
            end
        end
        model_ready = 1'b1;
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (model_ready) begin
            checks++;
            if (tone_det_n !== !m_present) begin
                errors++;
                $display("FAIL %s: tone_det_n=%0b expected %0b (model) at %0t",
                         phase, tone_det_n, !m_present, $time);
            end
        end
    end

    task automatic check_det(input bit exp, input string req);
        checks++;
        if (tone_det_n !== exp) begin
            errors++;
            $display("FAIL %s: tone_det_n=%0b expected %0b at %0t", req, tone_det_n, exp, $time);
        end
    endtask

    // One input cycle of p clocks, high for hi clocks; optional check 5 clocks
    // after the rise (exp < 0 skips it).
    task automatic pulse(input int p, input int hi, input int exp, input string req);
        phase = req;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            tone_sq = (i < hi);
            if (i == 5 && exp >= 0) check_det(exp[0], req);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk) tone_sq = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (5) @(negedge clk);
        check_det(1'b1, "R1");
        rst_n = 1'b1;

        // R1 then R3: first edge after reset is not enough, second in-band one is.
        pulse(NOM, NOM / 2, 1, "R1");
        pulse(NOM, NOM / 2, 0, "R3");
        pulse(NOM, NOM / 2, 0, "R3");

        // R5: exact release cycle after the last rise.
        pulse(NOM, NOM / 2, 0, "R5");
        idle(LONGEST + 3 - NOM);
        check_det(1'b0, "R5");
        idle(1);
        check_det(1'b1, "R5");
        idle(50);

        // R2: latency of the synchronizer and edge detector.
        pulse(NOM, NOM / 2, -1, "R2");
        phase = "R2";
        @(negedge clk) tone_sq = 1'b1;
        @(negedge clk);
        @(negedge clk) check_det(1'b1, "R2");
        @(negedge clk) check_det(1'b0, "R2");
        repeat (NOM / 2 - 4) @(negedge clk);
        idle(NOM - NOM / 2);

        // R6: band boundaries; each check judges the previous pulse length.
        idle(LONGEST + 10);
        pulse(SHORTEST, 40, 1, "R6");
        pulse(SHORTEST, 40, 0, "R6");
        pulse(LONGEST, 40, 0, "R6");
        pulse(SHORTEST - 1, 40, 0, "R6");
        pulse(NOM, 40, 1, "R6");
        pulse(LONGEST + 1, 40, 0, "R3");
        pulse(NOM, 40, 1, "R6");
        pulse(NOM, 40, 0, "R3");

        // R7: extreme duty cycles at a valid period.
        pulse(NOM, NOM / 10, 0, "R7");
        pulse(NOM, NOM / 10, 0, "R7");
        pulse(NOM, (NOM * 9) / 10, 0, "R7");
        pulse(NOM, (NOM * 9) / 10, 0, "R7");

        // R4: a glitch edge splits one cycle into two short periods.
        pulse(90, 10, 0, "R4");
        pulse(92, 10, 1, "R4");
        pulse(NOM, 40, 1, "R4");
        pulse(NOM, 40, 0, "R4");

        // R8: long silence; the counter must not wrap.
        idle(5000);
        check_det(1'b1, "R8");
        pulse(NOM, 40, 1, "R8");
        pulse(NOM, 40, 0, "R8");

        // R1: reset in the middle of a burst.
        pulse(NOM, 40, 0, "R3");
        phase = "R1";
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_det(1'b1, "R1");
        rst_n = 1'b1;
        pulse(NOM, 40, 1, "R1");
        pulse(NOM, 40, 0, "R3");
        idle(LONGEST + 10);
        check_det(1'b1, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule